// File: doc/BRIEF.md
# Addressing-Form Byte Parser

This block sits behind an instruction's opcode byte and takes in the bytes that describe its register/memory operand, one byte per clock whenever `in_valid` is high. The first byte is always the ModR/M byte. The parser splits it into fields and decides from the addressing size and the field values whether a scale/index/base (SIB) byte follows. It also works out how many displacement bytes come next. It gathers those bytes least significant first and presents a decoded operand record on the cycle the last byte is accepted. Opcode and prefix decoding, immediates and the address sum itself belong to neighbouring blocks.

The addressing size (`addr_mode`: 00 = 16-bit, 01 = 32-bit, 10 or 11 = 64-bit), the three register-extension prefix bits (`rex_r`, `rex_x`, `rex_b`) and the address-size override (`asz_ovr`) are taken from the ports in the cycle the ModR/M byte is accepted. They are held internally until the operand completes. The record outputs carry meaning only while `done` is high. Any selector whose `*_used` flag is low reads as 0, and `scale_log2` reads as 0 when no SIB byte is present.

A three-state machine drives the sequence:
- `ST_MODRM` waits for the ModR/M byte. It goes to `ST_SIB` when a SIB byte follows, otherwise to `ST_DISP` when a displacement follows. Otherwise it completes, raising `done`, and stays in `ST_MODRM`.
- `ST_SIB` goes to `ST_DISP` when a displacement follows. Otherwise it completes and returns to `ST_MODRM`.
- `ST_DISP` accepts displacement bytes and returns to `ST_MODRM`, raising `done`, on the last one.
- With `in_valid` low, every state holds.

Top module: `addr_form_parser`

## Requirements
- R1: The ModR/M byte splits as mode field in bits 7:6, register field in bits 5:3 and r/m field in bits 2:0. `reg_sel` is {extension bit R, bits 5:3} and `rm_sel` is {extension bit B, bits 2:0}.
- R2: A mode field of 11 gives `is_reg`=1, no SIB byte, no displacement and `byte_count`=1. `done` rises in the same cycle the ModR/M byte is accepted.
- R3: For memory forms, a mode field of 00 gives no displacement (except the special cases in R4, R6 and R7). A mode field of 01 gives one byte. A mode field of 10 gives two bytes in 16-bit addressing and four bytes otherwise.
- R4: 16-bit addressing never takes a SIB byte, and it maps r/m to base/index register numbers as follows: 000 BX(3)+SI(6), 001 BX+DI(7), 010 BP(5)+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. Mode 00 with r/m 110 instead means no base and a two-byte displacement.
- R5: In 32- and 64-bit addressing, a memory form with r/m 100 means a SIB byte follows, split as scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The outputs are `scale_log2`=scale, `index_sel`={X, index} and `base_sel`={B, base}.
- R6: In 32- and 64-bit addressing, mode 00 with r/m 101 means no base and a four-byte displacement. In 64-bit addressing this sets `ip_relative`, and `ip_narrow` follows `asz_ovr`.
- R7: With a SIB byte and mode 00, a base field of 101 means no base and a four-byte displacement.
- R8: The special cases in R5, R6 and R7 are detected with B ignored, so B=1 takes the same longer forms. An index field of 100 means no index only when X=0. With X=1 it selects register 12.
- R9: `disp_value` is the displacement, assembled least significant byte first and sign-extended to 32 bits. It is 0 when there is no displacement.
- R10: `byte_count` = 1 + (1 if a SIB byte) + displacement bytes. `done` is high only in the cycle the final byte is accepted.
- R11: While `in_valid` is low, no byte is accepted, `done` stays low and the parse position holds.
- R12: A synchronous reset returns the parser to waiting for a ModR/M byte, abandoning any partial operand.
- R13: Outside 64-bit addressing the extension bits R, X and B have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_byte` holds a byte to accept this cycle |
| in_byte | input | 8 | Next addressing-form byte |
| addr_mode | input | 2 | Addressing size: 00 16-bit, 01 32-bit, 1x 64-bit |
| rex_r | input | 1 | Register-field extension bit |
| rex_x | input | 1 | Index-field extension bit |
| rex_b | input | 1 | r/m or base extension bit |
| asz_ovr | input | 1 | Address-size override present |
| done | output | 1 | Operand complete this cycle |
| byte_count | output | 3 | Bytes consumed by the operand |
| is_reg | output | 1 | Operand is a register |
| reg_sel | output | 4 | Register-field operand number |
| rm_sel | output | 4 | Extended r/m field |
| sib_used | output | 1 | A SIB byte was consumed |
| scale_log2 | output | 2 | Index scale as a power of two |
| base_used | output | 1 | A base register takes part |
| base_sel | output | 4 | Base register number |
| index_used | output | 1 | An index register takes part |
| index_sel | output | 4 | Index register number |
| ip_relative | output | 1 | Address is relative to the instruction pointer |
| ip_narrow | output | 1 | Instruction-pointer base is 32-bit |
| disp_len | output | 3 | Displacement bytes: 0, 1, 2 or 4 |
| disp_value | output | 32 | Sign-extended displacement |

## Verification
The in-RTL assertions check, on every cycle, the following:
- `done` only with `in_valid`, and the return to `ST_MODRM` after it;
- the hold of state and gathered bytes while `in_valid` is low;
- the register form's one-byte length;
- the absence of SIB bytes in 16-bit addressing;
- the sign extension of a one-byte displacement;
- the absence of a base alongside instruction-pointer addressing;
- the silence of the extension bits outside 64-bit mode.

Only the bench scenarios can show that the right number of bytes is consumed for each special encoding, including B=1 and X=1. They also show that displacement bytes land in the right lanes, and that a reset in mid-operand discards the partial state.

// File: rtl/addr_form_pkg.sv
package addr_form_pkg;

    localparam int BYTE_W   = 8;
    localparam int DISP_W   = 32;
    localparam int LANES    = DISP_W / BYTE_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int SEL_W    = 4;
    localparam int LEN_W    = 3;
    localparam int DLEN_W   = 3;

    localparam logic [1:0] AM_16 = 2'b00;

    localparam logic [SEL_W-1:0] GP_BX = 4'd3;
    localparam logic [SEL_W-1:0] GP_BP = 4'd5;
    localparam logic [SEL_W-1:0] GP_SI = 4'd6;
    localparam logic [SEL_W-1:0] GP_DI = 4'd7;

    typedef enum logic [1:0] {
        ST_MODRM = 2'b00,
        ST_SIB   = 2'b01,
        ST_DISP  = 2'b10
    } step_t;

    typedef struct packed {
        logic             is_reg;
        logic [SEL_W-1:0] reg_sel;
        logic [SEL_W-1:0] rm_sel;
        logic             sib_used;
        logic [1:0]       scale_log2;
        logic             base_used;
        logic [SEL_W-1:0] base_sel;
        logic             index_used;
        logic [SEL_W-1:0] index_sel;
        logic             ip_relative;
        logic             ip_narrow;
    } operand_t;

endpackage

// File: rtl/af_field_decode.sv
module af_field_decode
    import addr_form_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    input  logic [BYTE_W-1:0] sib,
    input  logic [1:0]        mode,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    input  logic              ovr,
    output operand_t          rec,
    output logic              need_sib,
    output logic [DLEN_W-1:0] disp_n
);

    logic [1:0] f_mod;
    logic [2:0] f_reg;
    logic [2:0] f_rm;
    logic [1:0] f_scale;
    logic [2:0] f_index;
    logic [2:0] f_base;
    logic       narrow16;
    logic       wide64;
    logic       xr;
    logic       xx;
    logic       xb;

    assign f_mod    = modrm[7:6];
    assign f_reg    = modrm[5:3];
    assign f_rm     = modrm[2:0];
    assign f_scale  = sib[7:6];
    assign f_index  = sib[5:3];
    assign f_base   = sib[2:0];
    assign narrow16 = (mode == AM_16);
    assign wide64   = mode[1];
    assign xr       = ext_r & wide64;
    assign xx       = ext_x & wide64;
    assign xb       = ext_b & wide64;

    always_comb begin
        rec         = '0;
        need_sib    = 1'b0;
        disp_n      = '0;
        rec.reg_sel = {xr, f_reg};
        rec.rm_sel  = {xb, f_rm};

        if (f_mod == 2'b11) begin
            rec.is_reg = 1'b1;
        end else if (narrow16) begin
            unique case (f_mod)
                2'b01:   disp_n = 3'd1;
                2'b10:   disp_n = 3'd2;
                default: disp_n = (f_rm == 3'b110) ? 3'd2 : 3'd0;
            endcase
            unique case (f_rm)
                3'b000: begin
                    rec.base_used  = 1'b1; rec.base_sel  = GP_BX;
                    rec.index_used = 1'b1; rec.index_sel = GP_SI;
                end
                3'b001: begin
                    rec.base_used  = 1'b1; rec.base_sel  = GP_BX;
                    rec.index_used = 1'b1; rec.index_sel = GP_DI;
                end
                3'b010: begin
                    rec.base_used  = 1'b1; rec.base_sel  = GP_BP;
                    rec.index_used = 1'b1; rec.index_sel = GP_SI;
                end
                3'b011: begin
                    rec.base_used  = 1'b1; rec.base_sel  = GP_BP;
                    rec.index_used = 1'b1; rec.index_sel = GP_DI;
                end
                3'b100: begin
                    rec.base_used = 1'b1; rec.base_sel = GP_SI;
                end
                3'b101: begin
                    rec.base_used = 1'b1; rec.base_sel = GP_DI;
                end
                3'b110: begin
                    if (f_mod != 2'b00) begin
                        rec.base_used = 1'b1; rec.base_sel = GP_BP;
                    end
                end
                default: begin
                    rec.base_used = 1'b1; rec.base_sel = GP_BX;
                end
            endcase
        end else begin
            unique case (f_mod)
                2'b01:   disp_n = 3'd1;
                2'b10:   disp_n = 3'd4;
                default: disp_n = 3'd0;
            endcase
            // special forms are keyed on the raw 3-bit fields, B ignored
            if (f_rm == 3'b100) begin
                need_sib       = 1'b1;
                rec.sib_used   = 1'b1;
                rec.scale_log2 = f_scale;
                if ({xx, f_index} != 4'b0100) begin
                    rec.index_used = 1'b1;
                    rec.index_sel  = {xx, f_index};
                end
                if (f_mod == 2'b00 && f_base == 3'b101) begin
                    disp_n = 3'd4;
                end else begin
                    rec.base_used = 1'b1;
                    rec.base_sel  = {xb, f_base};
                end
            end else if (f_mod == 2'b00 && f_rm == 3'b101) begin
                disp_n          = 3'd4;
                rec.ip_relative = wide64;
                rec.ip_narrow   = wide64 & ovr;
            end else begin
                rec.base_used = 1'b1;
                rec.base_sel  = {xb, f_rm};
            end
        end
    end

endmodule

// File: rtl/af_disp_gather.sv
module af_disp_gather
    import addr_form_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              clear,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [DLEN_W-1:0] disp_n,
    output logic              last,
    output logic [DISP_W-1:0] disp_value
);

    logic [DISP_W-1:0] disp_q;
    logic [LANE_W-1:0] lane_q;
    logic [DISP_W-1:0] merged;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign merged[i*BYTE_W +: BYTE_W] =
                (take && lane_q == LANE_W'(i)) ? in_byte : disp_q[i*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign last = take && ((DLEN_W'(lane_q) + DLEN_W'(1)) == disp_n);

    always_comb begin
        unique case (disp_n)
            3'd1:    disp_value = {{(DISP_W-8){merged[7]}}, merged[7:0]};
            3'd2:    disp_value = {{(DISP_W-16){merged[15]}}, merged[15:0]};
            3'd4:    disp_value = merged;
            default: disp_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            disp_q <= '0;
            lane_q <= '0;
        end else if (take) begin
            disp_q <= merged;
            lane_q <= lane_q + LANE_W'(1);
        end
    end

    a_r11_lanes_hold: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> ($stable(disp_q) && $stable(lane_q)));

    a_r9_byte_sign: assert property (@(posedge clk) disable iff (rst)
        (disp_n == 3'd1) |-> (disp_value[DISP_W-1:8] == {(DISP_W-8){disp_value[7]}}));

endmodule

// File: rtl/af_step_fsm.sv
module af_step_fsm
    import addr_form_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              need_sib,
    input  logic [DLEN_W-1:0] disp_n,
    input  logic              disp_last,
    output step_t             state,
    output logic              done
);

    step_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_MODRM;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (in_valid) begin
            unique case (state)
                ST_MODRM: begin
                    if (need_sib)          nxt = ST_SIB;
                    else if (disp_n != '0) nxt = ST_DISP;
                end
                ST_SIB:   nxt = (disp_n != '0) ? ST_DISP : ST_MODRM;
                ST_DISP:  if (disp_last) nxt = ST_MODRM;
                default:  nxt = ST_MODRM;
            endcase
        end
    end

    always_comb begin
        done = 1'b0;
        if (in_valid) begin
            unique case (state)
                ST_MODRM: done = !need_sib && (disp_n == '0);
                ST_SIB:   done = (disp_n == '0);
                ST_DISP:  done = disp_last;
                default:  done = 1'b0;
            endcase
        end
    end

    a_r10_done_needs_valid: assert property (@(posedge clk) disable iff (rst)
        done |-> in_valid);

    a_r10_done_returns: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_MODRM));

    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state));

endmodule

// File: rtl/addr_form_parser.sv
module addr_form_parser
    import addr_form_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic [1:0]  addr_mode,
    input  logic        rex_r,
    input  logic        rex_x,
    input  logic        rex_b,
    input  logic        asz_ovr,
    output logic        done,
    output logic [2:0]  byte_count,
    output logic        is_reg,
    output logic [3:0]  reg_sel,
    output logic [3:0]  rm_sel,
    output logic        sib_used,
    output logic [1:0]  scale_log2,
    output logic        base_used,
    output logic [3:0]  base_sel,
    output logic        index_used,
    output logic [3:0]  index_sel,
    output logic        ip_relative,
    output logic        ip_narrow,
    output logic [2:0]  disp_len,
    output logic [31:0] disp_value
);

    step_t             state;
    logic              at_modrm;
    logic              at_sib;
    logic              take_disp;
    logic [BYTE_W-1:0] modrm_q;
    logic [BYTE_W-1:0] sib_q;
    logic [1:0]        mode_q;
    logic [2:0]        ext_q;
    logic              ovr_q;
    logic [BYTE_W-1:0] modrm_eff;
    logic [BYTE_W-1:0] sib_eff;
    logic [1:0]        mode_eff;
    logic [2:0]        ext_eff;
    logic              ovr_eff;
    operand_t          rec;
    logic              need_sib;
    logic [DLEN_W-1:0] disp_n;
    logic              disp_last;

    assign at_modrm  = (state == ST_MODRM);
    assign at_sib    = (state == ST_SIB);
    assign take_disp = in_valid && (state == ST_DISP);

    // the byte on the port counts as already captured in its own cycle
    assign modrm_eff = at_modrm ? in_byte : modrm_q;
    assign sib_eff   = at_sib   ? in_byte : sib_q;
    assign mode_eff  = at_modrm ? addr_mode : mode_q;
    assign ext_eff   = at_modrm ? {rex_r, rex_x, rex_b} : ext_q;
    assign ovr_eff   = at_modrm ? asz_ovr : ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            modrm_q <= '0;
            sib_q   <= '0;
            mode_q  <= '0;
            ext_q   <= '0;
            ovr_q   <= 1'b0;
        end else if (in_valid) begin
            if (at_modrm) begin
                modrm_q <= in_byte;
                mode_q  <= addr_mode;
                ext_q   <= {rex_r, rex_x, rex_b};
                ovr_q   <= asz_ovr;
            end
            if (at_sib) sib_q <= in_byte;
        end
    end

    af_field_decode u_decode (
        .modrm    (modrm_eff),
        .sib      (sib_eff),
        .mode     (mode_eff),
        .ext_r    (ext_eff[2]),
        .ext_x    (ext_eff[1]),
        .ext_b    (ext_eff[0]),
        .ovr      (ovr_eff),
        .rec      (rec),
        .need_sib (need_sib),
        .disp_n   (disp_n)
    );

    af_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .need_sib  (need_sib),
        .disp_n    (disp_n),
        .disp_last (disp_last),
        .state     (state),
        .done      (done)
    );

    af_disp_gather u_disp (
        .clk        (clk),
        .rst        (rst),
        .take       (take_disp),
        .clear      (done),
        .in_byte    (in_byte),
        .disp_n     (disp_n),
        .last       (disp_last),
        .disp_value (disp_value)
    );

    assign byte_count  = LEN_W'(1) + LEN_W'(rec.sib_used) + LEN_W'(disp_n);
    assign disp_len    = disp_n;
    assign is_reg      = rec.is_reg;
    assign reg_sel     = rec.reg_sel;
    assign rm_sel      = rec.rm_sel;
    assign sib_used    = rec.sib_used;
    assign scale_log2  = rec.scale_log2;
    assign base_used   = rec.base_used;
    assign base_sel    = rec.base_sel;
    assign index_used  = rec.index_used;
    assign index_sel   = rec.index_sel;
    assign ip_relative = rec.ip_relative;
    assign ip_narrow   = rec.ip_narrow;

    a_r2_reg_form_short: assert property (@(posedge clk) disable iff (rst)
        (done && is_reg) |-> (byte_count == 3'd1 && disp_len == 3'd0 && !sib_used));

    a_r4_no_sib_narrow: assert property (@(posedge clk) disable iff (rst)
        (done && mode_eff == AM_16) |-> !sib_used);

    a_r6_ip_no_base: assert property (@(posedge clk) disable iff (rst)
        (done && ip_relative) |-> (!base_used && !index_used && disp_len == 3'd4));

    a_r13_ext_silent: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_eff[1]) |-> (!reg_sel[3] && !rm_sel[3] && !base_sel[3] && !index_sel[3]));

endmodule

// File: tb/addr_form_parser_tb.sv
`timescale 1ns/1ps
module addr_form_parser_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [1:0]  addr_mode = '0;
    logic        rex_r = 0, rex_x = 0, rex_b = 0, asz_ovr = 0;
    logic        done;
    logic [2:0]  byte_count;
    logic        is_reg;
    logic [3:0]  reg_sel, rm_sel;
    logic        sib_used;
    logic [1:0]  scale_log2;
    logic        base_used;
    logic [3:0]  base_sel;
    logic        index_used;
    logic [3:0]  index_sel;
    logic        ip_relative, ip_narrow;
    logic [2:0]  disp_len;
    logic [31:0] disp_value;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    addr_form_parser u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .addr_mode(addr_mode), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
        .asz_ovr(asz_ovr), .done(done), .byte_count(byte_count), .is_reg(is_reg),
        .reg_sel(reg_sel), .rm_sel(rm_sel), .sib_used(sib_used),
        .scale_log2(scale_log2), .base_used(base_used), .base_sel(base_sel),
        .index_used(index_used), .index_sel(index_sel),
        .ip_relative(ip_relative), .ip_narrow(ip_narrow),
        .disp_len(disp_len), .disp_value(disp_value)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // expected record
    logic       e_isreg, e_sib, e_bu, e_iu, e_rip, e_nar;
    logic [3:0] e_reg, e_rm, e_bs, e_is;
    logic [1:0] e_sc;
    int         e_dn;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] md, input logic r, input logic x,
                                  input logic b, input logic o,
                                  input logic [7:0] mrm, input logic [7:0] sb);
        logic w64, w16;
        logic [1:0] mo;
        logic [2:0] rm;
        w64 = md[1];
        w16 = (md == 2'b00);
        mo  = mrm[7:6];
        rm  = mrm[2:0];
        e_isreg = 0; e_sib = 0; e_bu = 0; e_iu = 0; e_rip = 0; e_nar = 0;
        e_bs = 0; e_is = 0; e_sc = 0; e_dn = 0;
        e_reg = {r & w64, mrm[5:3]};
        e_rm  = {b & w64, rm};
        if (mo == 2'b11) begin
            e_isreg = 1;
        end else if (w16) begin
            e_dn = (mo == 2'b01) ? 1 : (mo == 2'b10) ? 2 : ((rm == 3'd6) ? 2 : 0);
            e_bu = 1;
            case (rm)
                3'd0: begin e_bs = 3; e_iu = 1; e_is = 6; end
                3'd1: begin e_bs = 3; e_iu = 1; e_is = 7; end
                3'd2: begin e_bs = 5; e_iu = 1; e_is = 6; end
                3'd3: begin e_bs = 5; e_iu = 1; e_is = 7; end
                3'd4: e_bs = 6;
                3'd5: e_bs = 7;
                3'd6: begin if (mo == 2'b00) e_bu = 0; else e_bs = 5; end
                default: e_bs = 3;
            endcase
        end else begin
            e_dn = (mo == 2'b01) ? 1 : (mo == 2'b10) ? 4 : 0;
            if (rm == 3'd4) begin
                e_sib = 1;
                e_sc  = sb[7:6];
                if (!(sb[5:3] == 3'd4 && !(x & w64))) begin
                    e_iu = 1; e_is = {x & w64, sb[5:3]};
                end
                if (mo == 2'b00 && sb[2:0] == 3'd5) e_dn = 4;
                else begin e_bu = 1; e_bs = {b & w64, sb[2:0]}; end
            end else if (mo == 2'b00 && rm == 3'd5) begin
                e_dn = 4; e_rip = w64; e_nar = w64 & o;
            end else begin
                e_bu = 1; e_bs = {b & w64, rm};
            end
        end
    endfunction

    function automatic logic [31:0] sext(input logic [31:0] raw, input int n);
        case (n)
            1: return {{24{raw[7]}}, raw[7:0]};
            2: return {{16{raw[15]}}, raw[15:0]};
            4: return raw;
            default: return 32'd0;
        endcase
    endfunction

    task automatic run_instr(input logic [1:0] md, input logic r, input logic x,
                             input logic b, input logic o, input logic [7:0] mrm,
                             input logic [7:0] sb, input logic [31:0] draw,
                             input int gap_pct);
        logic [7:0] seq [0:5];
        int n;
        model(md, r, x, b, o, mrm, sb);
        n = 0;
        seq[n] = mrm; n++;
        if (e_sib) begin seq[n] = sb; n++; end
        for (int k = 0; k < e_dn; k++) begin seq[n] = draw[8*k +: 8]; n++; end
        addr_mode = md; rex_r = r; rex_x = x; rex_b = b; asz_ovr = o;
        for (int j = 0; j < n; j++) begin
            while (int'($urandom % 100) < gap_pct) begin
                in_valid = 0;
                in_byte  = 8'($urandom);
                #1;
                chk("R11 idle done", 32'(done), 32'd0);
                @(negedge clk);
            end
            in_valid = 1;
            in_byte  = seq[j];
            #1;
            if (j < n - 1) begin
                chk("R10 early done", 32'(done), 32'd0);
            end else begin
                chk("R10 done", 32'(done), 32'd1);
                chk("R10 byte_count", 32'(byte_count), 32'(n));
                chk("R2 is_reg", 32'(is_reg), 32'(e_isreg));
                chk("R1 reg_sel", 32'(reg_sel), 32'(e_reg));
                chk("R1 rm_sel", 32'(rm_sel), 32'(e_rm));
                chk("R5 sib_used", 32'(sib_used), 32'(e_sib));
                chk("R5 scale", 32'(scale_log2), 32'(e_sc));
                chk("R4 base_used", 32'(base_used), 32'(e_bu));
                chk("R4 base_sel", 32'(base_sel), 32'(e_bs));
                chk("R8 index_used", 32'(index_used), 32'(e_iu));
                chk("R8 index_sel", 32'(index_sel), 32'(e_is));
                chk("R6 ip_relative", 32'(ip_relative), 32'(e_rip));
                chk("R6 ip_narrow", 32'(ip_narrow), 32'(e_nar));
                chk("R3 disp_len", 32'(disp_len), 32'(e_dn));
                chk("R9 disp_value", disp_value, sext(draw, e_dn));
            end
            @(negedge clk);
        end
        in_valid = 0;
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R12 reset idle done", 32'(done), 32'd0);
        @(negedge clk);

        // R2 register form, R1 fields
        run_instr(2'b01, 0, 0, 0, 0, 8'hC8, 8'h00, 32'h0, 0);
        // R3/R9 one-byte negative displacement
        run_instr(2'b01, 0, 0, 0, 0, 8'h40, 8'h00, 32'h0000_0080, 0);
        // R3/R4/R9 16-bit two-byte displacement, BP+SI
        run_instr(2'b00, 0, 0, 0, 0, 8'h82, 8'h00, 32'h0000_8001, 0);
        // R4 bare 16-bit displacement
        run_instr(2'b00, 0, 0, 0, 0, 8'h06, 8'h00, 32'h0000_1234, 0);
        // R4 r/m 100 in 16-bit mode is SI, no SIB
        run_instr(2'b00, 0, 0, 0, 0, 8'h04, 8'hFF, 32'h0, 0);
        // R5 SIB with scale and index
        run_instr(2'b01, 0, 0, 0, 0, 8'h04, 8'h88, 32'h0, 0);
        // R7 SIB no base, four-byte displacement
        run_instr(2'b01, 0, 0, 0, 0, 8'h04, 8'h4D, 32'h8765_4321, 0);
        // R6/R8 instruction-pointer relative with B=1, then narrow
        run_instr(2'b10, 0, 0, 1, 0, 8'h05, 8'h00, 32'hFFFF_FFF0, 0);
        run_instr(2'b10, 0, 0, 1, 1, 8'h05, 8'h00, 32'h0000_0100, 0);
        // R8 B=1 still takes SIB; index 100 with X=1 and X=0
        run_instr(2'b10, 1, 1, 1, 0, 8'h64, 8'hE5, 32'h0000_007F, 0);
        run_instr(2'b10, 0, 0, 1, 0, 8'h44, 8'h25, 32'h0000_0001, 0);
        // R13 extension bits ignored outside 64-bit
        run_instr(2'b01, 1, 1, 1, 1, 8'hFF, 8'h00, 32'h0, 0);
        run_instr(2'b00, 1, 1, 1, 1, 8'h80, 8'h00, 32'h0000_00FE, 0);
        // R11 stalls inside a long operand
        run_instr(2'b01, 0, 0, 0, 0, 8'h84, 8'h12, 32'hCAFE_F00D, 70);

        // R12 reset in mid-operand
        addr_mode = 2'b01; rex_r = 0; rex_x = 0; rex_b = 0; asz_ovr = 0;
        in_valid = 1; in_byte = 8'h80; @(negedge clk);
        in_byte = 8'h11; @(negedge clk);
        in_valid = 0; rst = 1; @(negedge clk);
        rst = 0;
        in_valid = 1; in_byte = 8'hD1;
        #1;
        chk("R12 restart done", 32'(done), 32'd1);
        chk("R12 restart count", 32'(byte_count), 32'd1);
        @(negedge clk);
        in_valid = 0;

        for (int t = 0; t < 400; t++) begin
            run_instr(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 8'($urandom), 8'($urandom), $urandom,
                      (t % 4 == 0) ? 40 : 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule